// File: doc/BRIEF.md
# Parallel NOR Flash Query and Geometry Discoverer

After reset this block takes control of a simple memory-style bus to a parallel NOR flash and works out what is attached. It resets the device, puts it into query mode, confirms that the query signature is present, and then reads the query table one byte at a time. The fields it reads are turned into values the rest of the chip can use directly: the command-set vendor code, the interface code, the device size in bytes, the write-buffer size in bytes, up to four erase-region descriptors (block size in bytes and block count) and three timeout values. Once decoding is complete it returns the device to read-array mode and pulses a done strobe.

The port width and the chip width are fixed by parameter. Query offset N is read at byte address N times the port width in bytes, and only the least significant byte lane of the returned word is used. Command words carry the command byte in the low byte of every chip-width lane of the port. If the signature does not match, the block reports the device as missing, stops reading and leaves every geometry output at zero. The bus has a fixed timing: read data is taken in the cycle after the read strobe.

Top module: `flash_geometry_probe`

## Requirements
- R1: After reset the first bus write is the reset command (byte 0xFF) at address 0, and the second is the query command (byte 0x98) at byte address 0x55 times the port width. Each command word carries the command byte in the low byte of every chip-width lane (with a 2-byte port and 1-byte chips: 0xFFFF, then 0x9898).
- R2: Every query read of offset N uses byte address N times the port width, and only bits 7:0 of the read data are used. The device is found only when offsets 0x10, 0x11 and 0x12 return 0x51, 0x52 and 0x59.
- R3: If any of the three signature bytes differs, the block reads no offset after the failing one, raises the missing flag instead of the found flag, and drives all geometry outputs to zero.
- R4: The vendor code is the 16-bit value with its low byte at offset 0x13 and high byte at 0x14; the interface code has its low byte at 0x28 and high byte at 0x29.
- R5: The device size output is 2 raised to the byte at offset 0x27, multiplied by the ratio of port width to chip width.
- R6: The write-buffer size output is 2 raised to the byte at offset 0x2A.
- R7: Each timeout output is 2 raised to the sum of its typical and maximum exponents, taken from offsets 0x1F and 0x23 for word write, 0x20 and 0x24 for buffer write, and 0x21 and 0x25 for block erase.
- R8: Erase region r is described by the four bytes at offsets 0x2D+4r to 0x30+4r, least significant first. Its block size is the low 16 bits times 256, or 128 when those bits are zero, and its block count is the upper 16 bits plus one.
- R9: The region count comes from offset 0x2C and is limited to 4. Only that many descriptors are read (no offset beyond the last one, and none beyond 0x2C when the count is zero) and descriptors past the count output zero size and count.
- R10: After the last read the block writes the reset command to address 0 and then holds the done output high for exactly one cycle, with the found or missing flag valid from that cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a new probe when released |
| memWe | output | 1 | Bus write strobe, one cycle per command |
| memRe | output | 1 | Bus read strobe; data is taken the following cycle |
| memAddr | output | 16 | Bus byte address |
| memWdata | output | 16 | Bus write data (command word) |
| memRdata | input | 16 | Bus read data |
| probeDone | output | 1 | One-cycle pulse when the probe has finished |
| devFound | output | 1 | Signature matched and geometry is valid |
| devMissing | output | 1 | Signature did not match |
| vendorId | output | 16 | Command-set vendor code |
| ifaceCode | output | 16 | Device interface code |
| devBytes | output | 32 | Device size in bytes |
| bufBytes | output | 32 | Write-buffer size in bytes |
| wordWriteTime | output | 32 | Word write timeout value |
| bufWriteTime | output | 32 | Buffer write timeout value |
| blockEraseTime | output | 32 | Block erase timeout value |
| regionCount | output | 3 | Number of reported erase regions (0 to 4) |
| regionBlkBytes | output | 96 | Block size of region r in bits 24r+23:24r |
| regionBlkCnt | output | 68 | Block count of region r in bits 17r+16:17r |

## Verification
A bench flash model answers query reads with the table in the low byte lane and a fixed non-zero pattern in the upper lane, so any use of the wrong lane or wrong address scaling shows up as a wrong decoded value. A typical table with two regions, one of them with a zero size field, checks every field decoder and separates the zero special case from a plain multiply. A table with a corrupted second signature byte separates the missing path from the found path and shows whether geometry is properly blanked and reading stops early. Tables declaring five and zero regions tell apart a correct cap and early exit from reading or reporting too many descriptors.

// File: rtl/probe_pkg.sv
package probe_pkg;

  localparam logic [7:0] CMD_RESET = 8'hFF;
  localparam logic [7:0] CMD_QUERY = 8'h98;
  localparam logic [7:0] QRY_OFF   = 8'h55;
  localparam int         FIRST_REG_IDX = 17;
  localparam logic [7:0] CNT_IDX   = 8'd16;

  typedef enum logic [2:0] {
    S_IDLE, S_RST, S_QRY, S_RD, S_WAIT, S_FIN, S_DONE, S_HALT
  } probeState_t;

  typedef struct packed {
    logic       capture;
    logic [7:0] idx;
  } dpCtl_t;

  // read step index to query table offset
  function automatic logic [7:0] offsetOf(input logic [7:0] idx);
    if (idx <= 8'd4)       offsetOf = 8'h10 + idx;
    else if (idx <= 8'd11) offsetOf = 8'h1A + idx;
    else if (idx <= 8'd15) offsetOf = 8'h1B + idx;
    else if (idx == 8'd16) offsetOf = 8'h2C;
    else                   offsetOf = 8'h1C + idx;
  endfunction

endpackage

// File: rtl/probe_ctrl.sv
module probe_ctrl
  import probe_pkg::*;
#(
  parameter int PB     = 2,
  parameter int CB     = 1,
  parameter int ADDR_W = 16,
  parameter int NREG   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sigMatch,
  input  logic [7:0]        rdByte,
  input  logic [7:0]        rawCnt,
  output dpCtl_t            ctl,
  output logic              memWe,
  output logic              memRe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [8*PB-1:0]   memWdata,
  output logic              probeDone,
  output logic              devFound,
  output logic              devMissing
);
  localparam int LANE_SH = $clog2(PB);

  probeState_t state;
  logic [7:0]  idx;
  logic        sigFail;
  logic [7:0]  capCnt;
  logic [7:0]  lastIdx;
  logic        lastRead;

  function automatic logic [8*PB-1:0] cmdWord(input logic [7:0] c);
    cmdWord = '0;
    for (int b = 0; b < PB; b++)
      if (b % CB == 0) cmdWord[8*b +: 8] = c;
  endfunction

  always_comb begin
    capCnt   = (rawCnt > 8'(NREG)) ? 8'(NREG) : rawCnt;
    lastIdx  = CNT_IDX + (capCnt << 2);
    lastRead = ((idx == CNT_IDX) && (rdByte == 8'h00)) ||
               ((idx > CNT_IDX) && (idx == lastIdx));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      idx        <= '0;
      sigFail    <= 1'b0;
      devFound   <= 1'b0;
      devMissing <= 1'b0;
    end else begin
      case (state)
        S_IDLE: state <= S_RST;
        S_RST:  state <= S_QRY;
        S_QRY: begin
          idx   <= '0;
          state <= S_RD;
        end
        S_RD:   state <= S_WAIT;
        S_WAIT: begin
          if ((idx <= 8'd2) && !sigMatch) begin
            sigFail <= 1'b1;
            state   <= S_FIN;
          end else if (lastRead) begin
            state <= S_FIN;
          end else begin
            idx   <= idx + 8'd1;
            state <= S_RD;
          end
        end
        S_FIN: begin
          devFound   <= !sigFail;
          devMissing <= sigFail;
          state      <= S_DONE;
        end
        S_DONE:  state <= S_HALT;
        default: state <= S_HALT;
      endcase
    end
  end

  always_comb begin
    memWe    = (state == S_RST) || (state == S_QRY) || (state == S_FIN);
    memRe    = (state == S_RD);
    memAddr  = '0;
    memWdata = '0;
    case (state)
      S_RST, S_FIN: memWdata = cmdWord(CMD_RESET);
      S_QRY: begin
        memWdata = cmdWord(CMD_QUERY);
        memAddr  = ADDR_W'(QRY_OFF) << LANE_SH;
      end
      S_RD:    memAddr = ADDR_W'(offsetOf(idx)) << LANE_SH;
      default: ;
    endcase
    ctl.capture = (state == S_WAIT);
    ctl.idx     = idx;
    probeDone   = (state == S_DONE);
  end

  // R10: done lasts a single cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
    probeDone |=> !probeDone);

  // R10: done follows the exit write to address 0
  a_r10_exit_before_done: assert property (@(posedge clk) disable iff (rst)
    $rose(probeDone) |-> ($past(memWe) && ($past(memAddr) == '0)));

  // R3: found and missing never together
  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(devFound && devMissing));

  // R2: bus never reads and writes in one cycle
  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(memWe && memRe));

endmodule

// File: rtl/probe_dpath.sv
module probe_dpath
  import probe_pkg::*;
#(
  parameter int NREG   = 4,
  parameter int SIZE_W = 32,
  parameter int TOUT_W = 32,
  parameter int RATIO  = 2,
  parameter int CNT_W  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  dpCtl_t              ctl,
  input  logic [7:0]          rdByte,
  input  logic                found,
  output logic                sigMatch,
  output logic [7:0]          rawCnt,
  output logic [15:0]         vendorId,
  output logic [15:0]         ifaceCode,
  output logic [SIZE_W-1:0]   devBytes,
  output logic [SIZE_W-1:0]   bufBytes,
  output logic [TOUT_W-1:0]   wordWriteTime,
  output logic [TOUT_W-1:0]   bufWriteTime,
  output logic [TOUT_W-1:0]   blockEraseTime,
  output logic [CNT_W-1:0]    regionCount,
  output logic [NREG*24-1:0]  regionBlkBytes,
  output logic [NREG*17-1:0]  regionBlkCnt
);
  localparam int RATIO_SH = $clog2(RATIO);

  logic [15:0] vendRaw, ifcRaw;
  logic [7:0]  sizeExp, bufExp;
  logic [7:0]  tExp [7];
  logic [7:0]  capCnt;

  always_comb begin
    case (ctl.idx)
      8'd0:    sigMatch = (rdByte == 8'h51);
      8'd1:    sigMatch = (rdByte == 8'h52);
      8'd2:    sigMatch = (rdByte == 8'h59);
      default: sigMatch = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vendRaw <= '0;
      ifcRaw  <= '0;
      sizeExp <= '0;
      bufExp  <= '0;
      rawCnt  <= '0;
      for (int i = 0; i < 7; i++) tExp[i] <= '0;
    end else if (ctl.capture) begin
      if (ctl.idx == 8'd3)  vendRaw[7:0]  <= rdByte;
      if (ctl.idx == 8'd4)  vendRaw[15:8] <= rdByte;
      if (ctl.idx >= 8'd5 && ctl.idx <= 8'd11)
        tExp[3'(ctl.idx - 8'd5)] <= rdByte;
      if (ctl.idx == 8'd12) sizeExp      <= rdByte;
      if (ctl.idx == 8'd13) ifcRaw[7:0]  <= rdByte;
      if (ctl.idx == 8'd14) ifcRaw[15:8] <= rdByte;
      if (ctl.idx == 8'd15) bufExp       <= rdByte;
      if (ctl.idx == CNT_IDX) rawCnt     <= rdByte;
    end
  end

  function automatic logic [TOUT_W-1:0] pow2(input logic [8:0] e);
    pow2 = (e >= 9'(TOUT_W)) ? '0 : (TOUT_W'(1) << e);
  endfunction

  always_comb begin
    capCnt         = (rawCnt > 8'(NREG)) ? 8'(NREG) : rawCnt;
    vendorId       = found ? vendRaw : '0;
    ifaceCode      = found ? ifcRaw : '0;
    devBytes       = found ? ((SIZE_W'(1) << sizeExp) << RATIO_SH) : '0;
    bufBytes       = found ? (SIZE_W'(1) << bufExp) : '0;
    wordWriteTime  = found ? pow2({1'b0, tExp[0]} + {1'b0, tExp[4]}) : '0;
    bufWriteTime   = found ? pow2({1'b0, tExp[1]} + {1'b0, tExp[5]}) : '0;
    blockEraseTime = found ? pow2({1'b0, tExp[2]} + {1'b0, tExp[6]}) : '0;
    regionCount    = found ? CNT_W'(capCnt) : '0;
  end

  for (genvar r = 0; r < NREG; r++) begin : g_region
    localparam logic [7:0] BASE = 8'(FIRST_REG_IDX + 4 * r);
    logic [31:0] desc;
    logic [7:0]  lane;
    logic        active;

    assign lane   = ctl.idx - BASE;
    assign active = found && (capCnt > 8'(r));

    always_ff @(posedge clk) begin
      if (rst) desc <= '0;
      else if (ctl.capture && ctl.idx >= BASE && ctl.idx < BASE + 8'd4)
        desc[8*lane[1:0] +: 8] <= rdByte;
    end

    assign regionBlkBytes[24*r +: 24] = !active ? 24'd0 :
      (desc[15:0] == 16'd0) ? 24'd128 : {desc[15:0], 8'h00};
    assign regionBlkCnt[17*r +: 17] = active ? ({1'b0, desc[31:16]} + 17'd1) : 17'd0;

    // R8: an active region never reports a block smaller than 128 bytes
    a_r8_min_block: assert property (@(posedge clk) disable iff (rst)
      active |-> (regionBlkBytes[24*r +: 24] >= 24'd128));
  end

  // R9: reported region count stays within the limit
  a_r9_count_cap: assert property (@(posedge clk) disable iff (rst)
    regionCount <= CNT_W'(NREG));

  // R3: geometry stays zero until the device is found
  a_r3_blank_when_absent: assert property (@(posedge clk) disable iff (rst)
    !found |-> (devBytes == '0 && vendorId == '0 && regionCount == '0));

endmodule

// File: rtl/flash_geometry_probe.sv
module flash_geometry_probe
  import probe_pkg::*;
#(
  parameter int PB     = 2,
  parameter int CB     = 1,
  parameter int ADDR_W = 16,
  parameter int NREG   = 4,
  parameter int SIZE_W = 32,
  parameter int TOUT_W = 32,
  localparam int CNT_W = $clog2(NREG + 1)
) (
  input  logic               clk,
  input  logic               rst,
  output logic               memWe,
  output logic               memRe,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [8*PB-1:0]    memWdata,
  input  logic [8*PB-1:0]    memRdata,
  output logic               probeDone,
  output logic               devFound,
  output logic               devMissing,
  output logic [15:0]        vendorId,
  output logic [15:0]        ifaceCode,
  output logic [SIZE_W-1:0]  devBytes,
  output logic [SIZE_W-1:0]  bufBytes,
  output logic [TOUT_W-1:0]  wordWriteTime,
  output logic [TOUT_W-1:0]  bufWriteTime,
  output logic [TOUT_W-1:0]  blockEraseTime,
  output logic [CNT_W-1:0]   regionCount,
  output logic [NREG*24-1:0] regionBlkBytes,
  output logic [NREG*17-1:0] regionBlkCnt
);
  dpCtl_t     ctl;
  logic       sigMatch;
  logic [7:0] rawCnt;
  logic [7:0] rdByte;

  assign rdByte = memRdata[7:0];

  probe_ctrl #(.PB(PB), .CB(CB), .ADDR_W(ADDR_W), .NREG(NREG)) u_ctrl (
    .clk(clk), .rst(rst), .sigMatch(sigMatch), .rdByte(rdByte), .rawCnt(rawCnt),
    .ctl(ctl), .memWe(memWe), .memRe(memRe), .memAddr(memAddr),
    .memWdata(memWdata), .probeDone(probeDone), .devFound(devFound),
    .devMissing(devMissing)
  );

  probe_dpath #(.NREG(NREG), .SIZE_W(SIZE_W), .TOUT_W(TOUT_W),
                .RATIO(PB / CB), .CNT_W(CNT_W)) u_dpath (
    .clk(clk), .rst(rst), .ctl(ctl), .rdByte(rdByte), .found(devFound),
    .sigMatch(sigMatch), .rawCnt(rawCnt), .vendorId(vendorId),
    .ifaceCode(ifaceCode), .devBytes(devBytes), .bufBytes(bufBytes),
    .wordWriteTime(wordWriteTime), .bufWriteTime(bufWriteTime),
    .blockEraseTime(blockEraseTime), .regionCount(regionCount),
    .regionBlkBytes(regionBlkBytes), .regionBlkCnt(regionBlkCnt)
  );

endmodule

// File: tb/flash_geometry_probe_test.sv
`timescale 1ns/1ps
module flash_geometry_probe_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        memWe, memRe;
  logic [15:0] memAddr, memWdata;
  logic [15:0] memRdata = 16'h0;
  logic        probeDone, devFound, devMissing;
  logic [15:0] vendorId, ifaceCode;
  logic [31:0] devBytes, bufBytes, wordWriteTime, bufWriteTime, blockEraseTime;
  logic [2:0]  regionCount;
  logic [95:0] regionBlkBytes;
  logic [67:0] regionBlkCnt;

  int checks = 0;
  int failures = 0;

  logic [7:0]  q [64];
  logic        qMode = 1'b0;
  int          wrN = 0;
  logic [15:0] wrA [8];
  logic [15:0] wrD [8];
  int          maxRd = 0;
  logic        misaligned = 1'b0;

  always #10 clk = ~clk;

  flash_geometry_probe uut (
    .clk(clk), .rst(rst), .memWe(memWe), .memRe(memRe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .probeDone(probeDone),
    .devFound(devFound), .devMissing(devMissing), .vendorId(vendorId),
    .ifaceCode(ifaceCode), .devBytes(devBytes), .bufBytes(bufBytes),
    .wordWriteTime(wordWriteTime), .bufWriteTime(bufWriteTime),
    .blockEraseTime(blockEraseTime), .regionCount(regionCount),
    .regionBlkBytes(regionBlkBytes), .regionBlkCnt(regionBlkCnt)
  );

  // flash model: query data in the low lane, junk in the upper lane
  always @(posedge clk) begin
    if (!rst && memRe) begin
      if (memAddr[0]) misaligned = 1'b1;
      if (int'(memAddr >> 1) > maxRd) maxRd = int'(memAddr >> 1);
      if (qMode && (memAddr >> 1) < 64) memRdata <= {8'hA5, q[memAddr[6:1]]};
      else memRdata <= 16'hA5A5;
    end
    if (!rst && memWe) begin
      if (wrN < 8) begin
        wrA[wrN] = memAddr;
        wrD[wrN] = memWdata;
      end
      wrN = wrN + 1;
      if (memWdata[7:0] == 8'h98 && memAddr == 16'h00AA) qMode = 1'b1;
      if (memWdata[7:0] == 8'hFF) qMode = 1'b0;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic loadTable(input int nReg);
    for (int i = 0; i < 64; i++) q[i] = 8'h00;
    q[8'h10] = 8'h51; q[8'h11] = 8'h52; q[8'h12] = 8'h59;
    q[8'h13] = 8'h02; q[8'h14] = 8'h01;
    q[8'h1F] = 8'd4;  q[8'h20] = 8'd5;  q[8'h21] = 8'd10; q[8'h22] = 8'd9;
    q[8'h23] = 8'd3;  q[8'h24] = 8'd3;  q[8'h25] = 8'd4;  q[8'h26] = 8'd7;
    q[8'h27] = 8'h18; q[8'h28] = 8'h02; q[8'h29] = 8'h03;
    q[8'h2A] = 8'd5;  q[8'h2B] = 8'h00;
    q[8'h2C] = 8'(nReg);
  endtask

  task automatic runProbe();
    int n;
    rst = 1'b1;
    wrN = 0; maxRd = 0; misaligned = 1'b0; qMode = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    n = 0;
    @(negedge clk);
    while (!probeDone && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(probeDone, "R10 done seen", 64'(probeDone), 64'd1);
  endtask

  task automatic checkCommands();
    chk(wrA[0] == 16'h0000 && wrD[0] == 16'hFFFF, "R1 first write reset",
        {wrA[0], wrD[0]}, {16'h0000, 16'hFFFF});
    chk(wrA[1] == 16'h00AA && wrD[1] == 16'h9898, "R1 second write query",
        {wrA[1], wrD[1]}, {16'h00AA, 16'h9898});
    chk(wrN == 3 && wrA[2] == 16'h0000 && wrD[2] == 16'hFFFF, "R10 exit reset write",
        {16'(wrN), wrA[2], wrD[2]}, {16'd3, 16'h0000, 16'hFFFF});
  endtask

  task automatic checkDonePulse();
    @(negedge clk);
    chk(!probeDone, "R10 done single cycle", 64'(probeDone), 64'd0);
  endtask

  task automatic tResetState();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!memWe && !memRe && !probeDone && !devFound && !devMissing,
        "R10 reset idle", {memWe, memRe, probeDone, devFound, devMissing}, 64'd0);
    chk(devBytes == 0 && vendorId == 0 && regionCount == 0 && regionBlkBytes == 0,
        "R3 reset geometry zero", 64'(devBytes), 64'd0);
  endtask

  task automatic tTypical();
    loadTable(2);
    q[8'h2D] = 8'h20; q[8'h2E] = 8'h00; q[8'h2F] = 8'h7E; q[8'h30] = 8'h00;
    q[8'h31] = 8'h00; q[8'h32] = 8'h00; q[8'h33] = 8'h03; q[8'h34] = 8'h00;
    runProbe();
    chk(devFound && !devMissing, "R2 signature found", {devFound, devMissing}, 64'h2);
    chk(!misaligned, "R2 read address scaling", 64'(misaligned), 64'd0);
    checkCommands();
    chk(vendorId == 16'h0102, "R4 vendor", 64'(vendorId), 64'h0102);
    chk(ifaceCode == 16'h0302, "R4 interface", 64'(ifaceCode), 64'h0302);
    chk(devBytes == 32'h0200_0000, "R5 device size", 64'(devBytes), 64'h0200_0000);
    chk(bufBytes == 32'd32, "R6 buffer size", 64'(bufBytes), 64'd32);
    chk(wordWriteTime == 32'd128, "R7 word write", 64'(wordWriteTime), 64'd128);
    chk(bufWriteTime == 32'd256, "R7 buffer write", 64'(bufWriteTime), 64'd256);
    chk(blockEraseTime == 32'd16384, "R7 block erase", 64'(blockEraseTime), 64'd16384);
    chk(regionCount == 3'd2, "R9 region count", 64'(regionCount), 64'd2);
    chk(regionBlkBytes[23:0] == 24'h002000 && regionBlkCnt[16:0] == 17'd127,
        "R8 region0", {regionBlkBytes[23:0], 7'd0, regionBlkCnt[16:0]},
        {24'h002000, 7'd0, 17'd127});
    chk(regionBlkBytes[47:24] == 24'd128 && regionBlkCnt[33:17] == 17'd4,
        "R8 region1 zero size field", {regionBlkBytes[47:24], 7'd0, regionBlkCnt[33:17]},
        {24'd128, 7'd0, 17'd4});
    chk(regionBlkBytes[95:48] == 0 && regionBlkCnt[67:34] == 0, "R9 unused regions zero",
        64'(regionBlkBytes[95:48]), 64'd0);
    chk(maxRd == 8'h34, "R9 last offset read", 64'(maxRd), 64'h34);
    checkDonePulse();
    chk(devFound && vendorId == 16'h0102, "R10 result held", 64'(vendorId), 64'h0102);
  endtask

  task automatic tMissing();
    loadTable(2);
    q[8'h11] = 8'h58;
    runProbe();
    chk(devMissing && !devFound, "R3 missing flag", {devFound, devMissing}, 64'h1);
    chk(vendorId == 0 && devBytes == 0 && bufBytes == 0 && wordWriteTime == 0 &&
        regionCount == 0 && regionBlkBytes == 0, "R3 geometry blank",
        64'(devBytes), 64'd0);
    chk(maxRd == 8'h11, "R3 reading stops", 64'(maxRd), 64'h11);
    checkCommands();
    checkDonePulse();
  endtask

  task automatic tFiveRegions();
    loadTable(5);
    for (int r = 0; r < 5; r++) begin
      q[8'h2D + 4*r]     = 8'(r + 1);
      q[8'h2D + 4*r + 1] = 8'h00;
      q[8'h2D + 4*r + 2] = 8'(r);
      q[8'h2D + 4*r + 3] = 8'h00;
    end
    runProbe();
    chk(regionCount == 3'd4, "R9 count capped", 64'(regionCount), 64'd4);
    chk(maxRd == 8'h3C, "R9 no read past fourth region", 64'(maxRd), 64'h3C);
    for (int r = 0; r < 4; r++)
      chk(regionBlkBytes[24*r +: 24] == 24'((r + 1) * 256) &&
          regionBlkCnt[17*r +: 17] == 17'(r + 1), "R8 capped region",
          {regionBlkBytes[24*r +: 24], 7'd0, regionBlkCnt[17*r +: 17]},
          {24'((r + 1) * 256), 7'd0, 17'(r + 1)});
    checkDonePulse();
  endtask

  task automatic tZeroRegions();
    loadTable(0);
    q[8'h2D] = 8'h11; q[8'h2F] = 8'h22;
    runProbe();
    chk(devFound && regionCount == 0, "R9 zero regions", 64'(regionCount), 64'd0);
    chk(regionBlkBytes == 0 && regionBlkCnt == 0, "R9 zero regions blank",
        64'(regionBlkBytes[23:0]), 64'd0);
    chk(maxRd == 8'h2C, "R9 stop at count byte", 64'(maxRd), 64'h2C);
    checkCommands();
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    tResetState();
    tTypical();
    tMissing();
    tFiveRegions();
    tZeroRegions();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule